// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block models a 16-bit parallel NOR flash that is driven by the widely used unlock-cycle command set. It sits behind a simple synchronous bus. Each cycle the bus can issue a write strobe with a word address and 16-bit data, a read strobe with a word address, or both. The storage is a small flop array split into equal sectors. Writes are interpreted as command cycles. A two-write unlock prefix guards every state-changing command.

The command decoder selects what a read returns: array contents, the identification words, the query table or a status word. Word program, sector erase and chip erase start a busy period whose length is set by parameters. During that period the `busy` output is high, every read returns a status word with a toggling bit, and all writes are ignored. An unlock-bypass mode shortens programming to two writes, so a host can fill many words quickly.

Top module: `nor_flash_ctrl`

## Requirements
- R1: A command sequence begins with 0xAA written at word address 0x5555, followed by 0x55 written at word address 0x2AAA. Only the low byte of write data is decoded as a command, and command addresses are compared on all address bits. A write that is not the expected next step abandons the sequence and returns the decoder to array-read mode without starting an operation.
- R2: After the unlock prefix, 0x90 written at 0x5555 enters identification mode. In that mode a read at word address low byte 0x00 returns 0x00BF, 0x01 returns 0x236D, and any other offset returns 0x0000. Writes other than 0xF0 are ignored in this mode. Writing 0xF0 at any address returns to array reads.
- R3: Writing 0x98 at word address 0x55 from array-read mode enters query mode. Reads are selected by word address bits 7:0. 0x10, 0x11 and 0x12 return 0x0051, 0x0052 and 0x0059, and 0x2C returns 1. 0x2D and 0x2E return the sector count minus one, low byte first. 0x2F and 0x30 return the sector size in bytes divided by 256, low byte first. Other offsets return 0. Writing 0xF0 leaves the mode.
- R4: After the unlock prefix, 0xA0 at 0x5555 followed by a data write programs the word at that write's address. The new contents are the old contents ANDed with the data, and `busy` is then high for exactly PROG_CYC cycles.
- R5: After the unlock prefix, 0x80 at 0x5555 and a second unlock prefix, writing 0x30 at any address erases only the sector selected by the upper array-address bits, so all its words read 0xFFFF. `busy` stays high for max(SECT_ERASE_CYC, SECT_WORDS) cycles.
- R6: The same six-write form ending with 0x10 at 0x5555 erases every word to 0xFFFF. `busy` stays high for max(CHIP_ERASE_CYC, total words) cycles.
- R7: While busy, a read returns a status word. Bit 7 is 0 during an erase and the inverse of bit 7 of the programmed data during a program. Bit 6 inverts on every status read. All other bits are 0. After busy ends, consecutive reads are equal and return array data.
- R8: Every write received while `busy` is high is ignored. It neither advances a sequence nor alters the array.
- R9: After the unlock prefix, 0x20 at 0x5555 enters bypass mode. There, 0xA0 at any address followed by a data write programs as in R4 and stays in bypass mode. Any other write, such as 0x00, leaves bypass mode, and a following two-write program is then ignored.
- R10: After reset, `busy` is 0, `rd_data` is 0, the decoder is in array-read mode and every array word reads 0xFFFF.
- R11: `rd_data` is registered. It reflects a read strobe at the next clock edge and holds its value on cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data or command byte (low byte) |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| busy | output | 1 | High while a program or erase is running |

## Verification
A decoder stuck in the wrong state shows at the next read. That read returns an identification word, a query word or array data where another source was expected, or a missing or unexpected `busy` rise follows the final write of a sequence in the same cycle. A corrupted busy counter shows as a busy window of the wrong length, which the bench measures cycle by cycle. A faulty erase sweep or program merge is caught by full-array sweeps compared with a model after every operation. A stuck status toggle is exposed by the second of two back-to-back status reads.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;

    typedef logic [15:0] word_t;

    typedef enum logic [3:0] {
        SQ_READ, SQ_UNL1, SQ_UNL2, SQ_ESET, SQ_EUNL1, SQ_EUNL2,
        SQ_PROG, SQ_ID, SQ_QRY, SQ_BYP, SQ_BPROG
    } seq_state_e;

    typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_SECT, OP_CHIP} op_kind_e;

    localparam logic [14:0] KEY_ADDR_A = 15'h5555;
    localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;
    localparam logic [14:0] QRY_ADDR   = 15'h0055;

    localparam logic [7:0] C_KEY_A   = 8'hAA;
    localparam logic [7:0] C_KEY_B   = 8'h55;
    localparam logic [7:0] C_ID      = 8'h90;
    localparam logic [7:0] C_QRY     = 8'h98;
    localparam logic [7:0] C_EXIT    = 8'hF0;
    localparam logic [7:0] C_PROG    = 8'hA0;
    localparam logic [7:0] C_ESETUP  = 8'h80;
    localparam logic [7:0] C_SECT    = 8'h30;
    localparam logic [7:0] C_CHIP    = 8'h10;
    localparam logic [7:0] C_BYPASS  = 8'h20;

    function automatic word_t id_word(input logic [7:0] off);
        case (off)
            8'h00:   return 16'h00BF;
            8'h01:   return 16'h236D;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic word_t query_word(input logic [7:0] off,
                                         input int unsigned nsect,
                                         input int unsigned sect_bytes);
        int unsigned cnt_m1;
        int unsigned units;
        cnt_m1 = nsect - 1;
        units  = sect_bytes >> 8;
        case (off)
            8'h10:   return 16'h0051;
            8'h11:   return 16'h0052;
            8'h12:   return 16'h0059;
            8'h2C:   return 16'h0001;
            8'h2D:   return 16'(cnt_m1 & 32'hFF);
            8'h2E:   return 16'((cnt_m1 >> 8) & 32'hFF);
            8'h2F:   return 16'(units & 32'hFF);
            8'h30:   return 16'((units >> 8) & 32'hFF);
            default: return 16'h0000;
        endcase
    endfunction

    function automatic word_t status_word(input op_kind_e kind,
                                          input logic tgl,
                                          input logic prog_inv7);
        logic b7;
        b7 = (kind == OP_PROG) ? prog_inv7 : 1'b0;
        return {8'h00, b7, tgl, 6'b000000};
    endfunction

endpackage

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_flash_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        cmd,
    input  logic              busy,
    output seq_state_e        state,
    output op_kind_e          op_start
);

    localparam logic [ADDR_W-1:0] KA = ADDR_W'(KEY_ADDR_A);
    localparam logic [ADDR_W-1:0] KB = ADDR_W'(KEY_ADDR_B);
    localparam logic [ADDR_W-1:0] QA = ADDR_W'(QRY_ADDR);

    seq_state_e st_q, st_d;
    op_kind_e   kind_d;
    logic       acc;

    assign acc = wr_en && !busy;

    always_comb begin
        st_d   = st_q;
        kind_d = OP_NONE;
        if (acc) begin
            case (st_q)
                SQ_READ: begin
                    if (cmd == C_KEY_A && addr == KA)     st_d = SQ_UNL1;
                    else if (cmd == C_QRY && addr == QA)  st_d = SQ_QRY;
                end
                SQ_UNL1:  st_d = (cmd == C_KEY_B && addr == KB) ? SQ_UNL2 : SQ_READ;
                SQ_UNL2: begin
                    st_d = SQ_READ;
                    if (addr == KA) begin
                        case (cmd)
                            C_ID:     st_d = SQ_ID;
                            C_PROG:   st_d = SQ_PROG;
                            C_ESETUP: st_d = SQ_ESET;
                            C_BYPASS: st_d = SQ_BYP;
                            default:  st_d = SQ_READ;
                        endcase
                    end
                end
                SQ_ESET:  st_d = (cmd == C_KEY_A && addr == KA) ? SQ_EUNL1 : SQ_READ;
                SQ_EUNL1: st_d = (cmd == C_KEY_B && addr == KB) ? SQ_EUNL2 : SQ_READ;
                SQ_EUNL2: begin
                    st_d = SQ_READ;
                    if (cmd == C_SECT)                    kind_d = OP_SECT;
                    else if (cmd == C_CHIP && addr == KA) kind_d = OP_CHIP;
                end
                SQ_PROG: begin
                    kind_d = OP_PROG;
                    st_d   = SQ_READ;
                end
                SQ_ID, SQ_QRY: begin
                    if (cmd == C_EXIT) st_d = SQ_READ;
                end
                SQ_BYP:   st_d = (cmd == C_PROG) ? SQ_BPROG : SQ_READ;
                SQ_BPROG: begin
                    kind_d = OP_PROG;
                    st_d   = SQ_BYP;
                end
                default:  st_d = SQ_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= SQ_READ;
        else     st_q <= st_d;
    end

    assign state    = st_q;
    assign op_start = kind_d;

    // R8
    busy_freezes_seq_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(st_q));

    // R4
    prog_data_returns_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && st_q == SQ_PROG) |=> (st_q == SQ_READ));

endmodule

// File: rtl/nor_op_timer.sv
module nor_op_timer
    import nor_flash_pkg::*;
#(
    parameter int PROG_CYC       = 8,
    parameter int SECT_ERASE_CYC = 200,
    parameter int CHIP_ERASE_CYC = 600,
    parameter int SECT_WORDS     = 128,
    parameter int NUM_SECT       = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  op_kind_e                          start_kind,
    input  logic [$clog2(NUM_SECT)-1:0]       start_sect,
    output logic                              busy,
    output op_kind_e                          run_kind,
    output logic                              sweep_we,
    output logic [$clog2(SECT_WORDS*NUM_SECT)-1:0] sweep_idx
);

    localparam int TOTAL = SECT_WORDS * NUM_SECT;
    localparam int AW    = $clog2(TOTAL);
    localparam int SAW   = $clog2(SECT_WORDS);
    localparam int LW    = AW + 1;
    localparam int SD    = (SECT_ERASE_CYC > SECT_WORDS) ? SECT_ERASE_CYC : SECT_WORDS;
    localparam int CD    = (CHIP_ERASE_CYC > TOTAL) ? CHIP_ERASE_CYC : TOTAL;
    localparam int DM1   = (SD > CD) ? SD : CD;
    localparam int DMAX  = (DM1 > PROG_CYC) ? DM1 : PROG_CYC;
    localparam int CW    = $clog2(DMAX + 1);

    logic           busy_q;
    op_kind_e       kind_q;
    logic [CW-1:0]  cnt_q;
    logic [AW-1:0]  ptr_q;
    logic [LW-1:0]  left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            kind_q <= OP_NONE;
            cnt_q  <= '0;
            ptr_q  <= '0;
            left_q <= '0;
        end else if (start_kind != OP_NONE) begin
            busy_q <= 1'b1;
            kind_q <= start_kind;
            case (start_kind)
                OP_SECT: begin
                    cnt_q  <= CW'(SD - 1);
                    ptr_q  <= {start_sect, {SAW{1'b0}}};
                    left_q <= LW'(SECT_WORDS);
                end
                OP_CHIP: begin
                    cnt_q  <= CW'(CD - 1);
                    ptr_q  <= '0;
                    left_q <= LW'(TOTAL);
                end
                default: begin
                    cnt_q  <= CW'(PROG_CYC - 1);
                    left_q <= '0;
                end
            endcase
        end else if (busy_q) begin
            if (left_q != '0) begin
                ptr_q  <= ptr_q + 1'b1;
                left_q <= left_q - 1'b1;
            end
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
                kind_q <= OP_NONE;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy      = busy_q;
    assign run_kind  = kind_q;
    assign sweep_we  = busy_q && (left_q != '0);
    assign sweep_idx = ptr_q;

    // R5
    sweep_done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> (left_q == '0));

endmodule

// File: rtl/nor_word_array.sv
module nor_word_array
    import nor_flash_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     prog_we,
    input  logic [$clog2(DEPTH)-1:0] prog_idx,
    input  word_t                    prog_data,
    input  logic                     sweep_we,
    input  logic [$clog2(DEPTH)-1:0] sweep_idx,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output word_t                    rd_word
);

    word_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 16'hFFFF;
        end else begin
            if (sweep_we) mem_q[sweep_idx] <= 16'hFFFF;
            if (prog_we)  mem_q[prog_idx]  <= mem_q[prog_idx] & prog_data;
        end
    end

    assign rd_word = mem_q[rd_idx];

    // R4
    program_clears_only_chk: assert property (@(posedge clk) disable iff (rst)
        prog_we |=> (mem_q[$past(prog_idx)] == ($past(mem_q[prog_idx]) & $past(prog_data))));

    // R5
    sweep_writes_ones_chk: assert property (@(posedge clk) disable iff (rst)
        sweep_we |=> (mem_q[$past(sweep_idx)] == 16'hFFFF));

endmodule

// File: rtl/nor_flash_ctrl.sv
module nor_flash_ctrl
    import nor_flash_pkg::*;
#(
    parameter int ADDR_W         = 15,
    parameter int SECT_WORDS     = 128,
    parameter int NUM_SECT       = 4,
    parameter int PROG_CYC       = 8,
    parameter int SECT_ERASE_CYC = 200,
    parameter int CHIP_ERASE_CYC = 600
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [15:0]       wr_data,
    input  logic              rd_en,
    output logic [15:0]       rd_data,
    output logic              busy
);

    localparam int TOTAL = SECT_WORDS * NUM_SECT;
    localparam int AW    = $clog2(TOTAL);
    localparam int SAW   = $clog2(SECT_WORDS);
    localparam int SSW   = $clog2(NUM_SECT);

    seq_state_e    seq_state;
    op_kind_e      op_start;
    op_kind_e      run_kind;
    logic          busy_w;
    logic          sweep_we;
    logic [AW-1:0] sweep_idx;
    word_t         arr_word;
    word_t         rd_d;
    logic          tgl_q;
    logic          inv7_q;
    word_t         rd_q;

    nor_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .cmd      (wr_data[7:0]),
        .busy     (busy_w),
        .state    (seq_state),
        .op_start (op_start)
    );

    nor_op_timer #(
        .PROG_CYC       (PROG_CYC),
        .SECT_ERASE_CYC (SECT_ERASE_CYC),
        .CHIP_ERASE_CYC (CHIP_ERASE_CYC),
        .SECT_WORDS     (SECT_WORDS),
        .NUM_SECT       (NUM_SECT)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .start_kind (op_start),
        .start_sect (addr[AW-1:AW-SSW]),
        .busy       (busy_w),
        .run_kind   (run_kind),
        .sweep_we   (sweep_we),
        .sweep_idx  (sweep_idx)
    );

    nor_word_array #(.DEPTH(TOTAL)) u_array (
        .clk       (clk),
        .rst       (rst),
        .prog_we   (op_start == OP_PROG),
        .prog_idx  (addr[AW-1:0]),
        .prog_data (wr_data),
        .sweep_we  (sweep_we),
        .sweep_idx (sweep_idx),
        .rd_idx    (addr[AW-1:0]),
        .rd_word   (arr_word)
    );

    always_comb begin
        if (busy_w) begin
            rd_d = status_word(run_kind, tgl_q, inv7_q);
        end else begin
            case (seq_state)
                SQ_ID:   rd_d = id_word(addr[7:0]);
                SQ_QRY:  rd_d = query_word(addr[7:0], NUM_SECT, SECT_WORDS * 2);
                default: rd_d = arr_word;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q   <= '0;
            tgl_q  <= 1'b0;
            inv7_q <= 1'b0;
        end else begin
            if (op_start == OP_PROG) inv7_q <= ~wr_data[7];
            if (rd_en) begin
                rd_q <= rd_d;
                if (busy_w) tgl_q <= ~tgl_q;
            end
        end
    end

    assign rd_data = rd_q;
    assign busy    = busy_w;

    // R8
    no_start_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy_w |-> (op_start == OP_NONE));

    // R7
    erase_status_bit7_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy_w && (run_kind == OP_SECT || run_kind == OP_CHIP)) |=> (rd_q[7] == 1'b0));

    // R7
    status_toggles_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy_w && $past(rd_en && busy_w)) |=> (rd_q[6] != $past(rd_q[6])));

    // R11
    read_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_q));

endmodule

// File: tb/tb_nor_flash_ctrl.sv
module tb_nor_flash_ctrl;

    localparam int ADDR_W = 15;
    localparam int SW     = 128;
    localparam int NS     = 4;
    localparam int TOT    = SW * NS;
    localparam int PC     = 8;
    localparam int SEC    = 200;
    localparam int CHC    = 600;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic [15:0]       wr_data = '0;
    logic              rd_en = 1'b0;
    logic [15:0]       rd_data;
    logic              busy;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [15:0] em [TOT];

    always #2 clk = ~clk;

    nor_flash_ctrl #(
        .ADDR_W(ADDR_W), .SECT_WORDS(SW), .NUM_SECT(NS),
        .PROG_CYC(PC), .SECT_ERASE_CYC(SEC), .CHIP_ERASE_CYC(CHC)
    ) dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .busy(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        addr = ADDR_W'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        addr = ADDR_W'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic unlock();
        wr(16'h5555, 16'h00AA);
        wr(16'h2AAA, 16'h0055);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic sweep(input string tag);
        logic [15:0] v;
        int bad = 0;
        logic [15:0] fa = '0;
        logic [15:0] fe = '0;
        int fi = 0;
        for (int i = 0; i < TOT; i++) begin
            rd(i, v);
            if (v !== em[i]) begin
                if (bad == 0) begin fa = v; fe = em[i]; fi = i; end
                bad++;
            end
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s: word %0d actual=0x%0h expected=0x%0h (%0d bad)", tag, fi, fa, fe, bad);
        end
    endtask

    function automatic logic [15:0] pat1(input int i);
        return 16'((i * 40503) ^ 16'h5A5A);
    endfunction

    function automatic logic [15:0] pat2(input int i);
        return 16'(~(i << 3) ^ (i >> 2));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, v2;
        int n;
        for (int i = 0; i < TOT; i++) em[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        chk("R10 rd_data after reset", rd_data, 0);
        chk("R10 busy after reset", busy, 0);
        sweep("R10 erased array after reset");

        // R11 registered read holds without strobe
        rd(3, v);
        repeat (3) @(negedge clk);
        chk("R11 rd_data holds", rd_data, 16'hFFFF);

        // R2 identification mode
        unlock();
        wr(16'h5555, 16'h0090);
        rd(0, v); chk("R2 manufacturer word", v, 16'h00BF);
        rd(1, v); chk("R2 device word", v, 16'h236D);
        rd(2, v); chk("R2 other offset", v, 16'h0000);
        wr(16'h5555, 16'h00AA);
        rd(0, v); chk("R2 non-exit write ignored", v, 16'h00BF);
        wr(16'h0123, 16'h00F0);
        rd(0, v); chk("R2 exit to array", v, 16'hFFFF);

        // R3 query table
        wr(16'h0055, 16'h0098);
        rd(16'h10, v); chk("R3 Q", v, 16'h0051);
        rd(16'h11, v); chk("R3 R", v, 16'h0052);
        rd(16'h12, v); chk("R3 Y", v, 16'h0059);
        rd(16'h2C, v); chk("R3 regions", v, 1);
        rd(16'h2D, v); chk("R3 count lo", v, (NS - 1) & 255);
        rd(16'h2E, v); chk("R3 count hi", v, ((NS - 1) >> 8) & 255);
        rd(16'h2F, v); chk("R3 size lo", v, ((SW * 2) / 256) & 255);
        rd(16'h30, v); chk("R3 size hi", v, ((SW * 2) / 256) >> 8);
        wr(0, 16'h00F0);
        rd(16'h10, v); chk("R3 exit to array", v, 16'hFFFF);

        // R4 program with AND and busy length
        unlock();
        wr(16'h5555, 16'h00A0);
        wr(5, 16'h5555);
        chk("R4 busy rises after data write", busy, 1);
        wait_idle(n);
        chk("R4 busy cycles", n, PC);
        em[5] = 16'h5555;
        rd(5, v); chk("R4 first program", v, 16'h5555);
        unlock();
        wr(16'h5555, 16'h00A0);
        wr(5, 16'hAA55);
        rd(5, v);
        chk("R7 program status word", v & 16'hFFBF, 16'h0080);
        wait_idle(n);
        em[5] = 16'h0055;
        rd(5, v); chk("R4 AND result", v, 16'h0055);

        // R1 abandoned sequences
        wr(16'h5555, 16'h00AA);
        wr(16'h2AAB, 16'h0055);
        wr(16'h5555, 16'h00A0);
        wr(10, 16'h0000);
        chk("R1 wrong unlock address starts nothing", busy, 0);
        rd(10, v); chk("R1 wrong unlock leaves word", v, 16'hFFFF);
        unlock();
        wr(16'h5555, 16'h0077);
        wr(20, 16'h0000);
        chk("R1 bad command starts nothing", busy, 0);
        rd(20, v); chk("R1 bad command leaves word", v, 16'hFFFF);

        // R9 bypass programming over the whole array, A0 away from 0x5555
        unlock();
        wr(16'h5555, 16'h0020);
        for (int i = 0; i < TOT; i++) begin
            wr(7, 16'h00A0);
            wr(i, pat1(i));
            wait_idle(n);
            em[i] = em[i] & pat1(i);
        end
        for (int i = 0; i < TOT; i++) begin
            wr(16'h1000 + i, 16'h00A0);
            wr(i, pat2(i));
            wait_idle(n);
            em[i] = em[i] & pat2(i);
        end
        wr(0, 16'h0000);
        wr(8, 16'h00A0);
        wr(8, 16'h55AA);
        chk("R9 program after exit starts nothing", busy, 0);
        sweep("R9 bypass programs and ignored program after exit");

        // R5 sector erase with status reads and writes during busy
        unlock();
        wr(16'h5555, 16'h0080);
        unlock();
        wr(2 * SW + 5, 16'h0030);
        rd(2 * SW, v);
        rd(2 * SW, v2);
        chk("R7 erase status bit7", v[7], 0);
        chk("R7 erase status toggle", v[6] ^ v2[6], 1);
        chk("R7 erase status other bits", v & 16'hFFBF, 0);
        unlock();
        wr(16'h5555, 16'h00A0);
        wr(0, 16'h0000);
        wait_idle(n);
        chk("R5 sector erase busy cycles", n + 6, SEC);
        for (int i = 2 * SW; i < 3 * SW; i++) em[i] = 16'hFFFF;
        rd(0, v); rd(0, v2);
        chk("R7 reads equal after erase", v, v2);
        chk("R8 write during busy ignored", v, em[0]);
        sweep("R5 only selected sector erased");

        // R6 chip erase
        unlock();
        wr(16'h5555, 16'h0080);
        unlock();
        wr(16'h5555, 16'h0010);
        rd(0, v);
        rd(0, v2);
        chk("R7 chip erase status bit7", v[7], 0);
        chk("R7 chip erase toggle", v[6] ^ v2[6], 1);
        wait_idle(n);
        chk("R6 chip erase busy cycles", n + 2, CHC);
        for (int i = 0; i < TOT; i++) em[i] = 16'hFFFF;
        sweep("R6 whole array erased");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule